// File: doc/BRIEF.md
# Shared Timer with Per-Core Comparators

A system timer for a small multiprocessor cluster. All cores share one free-running 64-bit up-counter. Each core owns a private 64-bit compare value, an auto-increment step and an interrupt line. The interrupt lines are meant to be wired to every core's private interrupt input at the same banked slot (number 27), not to a shared interrupt. A match never stops or reloads the counter: it keeps counting, and a core with auto-increment enabled keeps getting interrupts at a fixed period.

Software reaches the block through a 32-bit register port. Each request carries the ID of the core that issues it. Counter and global control are common to all cores. The core control, status, compare and increment registers are banked, so each core reaches only its own copy. A 64-bit value is split into two 32-bit halves at adjacent offsets. To get a consistent counter value, read the upper half, then the lower half, then the upper half again, and retry if the two upper reads differ.

Register offsets on `req_addr`:
- 0: counter bits 31:0 (shared)
- 1: counter bits 63:32 (shared)
- 2: global control (shared), with bit 0 = run and bits 15:8 = prescale
- 3: core control (banked), with bit 0 = compare enable, bit 1 = interrupt enable and bit 2 = auto-increment
- 4: status (banked), with bit 0 = event flag
- 5: compare bits 31:0 (banked)
- 6: compare bits 63:32 (banked)
- 7: increment step, 32 bits (banked)

Top module: `cluster_timer`

## Requirements
- R1: After reset the counter, global control, all banked registers, all event flags and all `irq` bits read 0.
- R2: While run (offset 2 bit 0) is 1, the counter increments by one once every prescale+1 clock cycles, where prescale is offset 2 bits 15:8. While run is 0 the counter holds its value.
- R3: The counter is 64 bits wide. An increment carries from bit 31 into bit 32. A write to offset 0 or 1 replaces that half and suppresses the increment in that cycle.
- R4: Offsets 3 to 7 go to the bank selected by `req_core`, and an access never changes or returns another core's bank. Offsets 0 to 2 are the same for every core.
- R5: A core's event flag is set one cycle after its counter-to-compare test becomes true. The test is true when compare enable is 1, the comparator is armed, and counter >= compare (unsigned). A compare value already below the counter therefore fires on the next cycle.
- R6: With auto-increment at 0, the comparator disarms when it fires. It does not fire again until its compare value (offset 5 or 6) or its core control (offset 3) is written.
- R7: With auto-increment at 1, each match adds the increment step to the compare value and the comparator stays armed. Matches then recur every step*(prescale+1) cycles.
- R8: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it set. A match in the same cycle wins over the clear.
- R9: `irq[i]` is 1 exactly when core i's event flag and interrupt enable (offset 3 bit 1) are both 1.
- R10: A match leaves the counter running: the counter is never reloaded or stopped by a comparator.
- R11: Read data appears on `rsp_rdata` in the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_core | input | CORE_W | ID of the requesting core, which selects the bank |
| req_addr | input | 3 | Register offset |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| irq | output | NUM_CORES | Per-core private interrupt |

## Verification
A register write takes effect at the clock edge that samples it. A read returns the value the register held just before that edge, on the following cycle. The event flag, and `irq` with it, rises one edge after the counter reaches the compare value. An interrupt enable write shows on `irq` right after its edge. The bench drives every request at a falling edge and samples one falling edge later. For each flag check it counts the exact number of extra edges needed. Periods are measured as the number of rising edges between two observed rises of `irq`.

// File: rtl/ctmr_pkg.sv
// Package: shared constants and register offsets for the cluster timer.
// Assumes a 32-bit register port and a 64-bit counter split in two halves.
package ctmr_pkg;
    localparam int CNT_W  = 64;
    localparam int HALF_W = CNT_W / 2;
    localparam int PRE_W  = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RS_CNT_LO    = 3'd0,
        RS_CNT_HI    = 3'd1,
        RS_GCTRL     = 3'd2,
        RS_CORE_CTRL = 3'd3,
        RS_STATUS    = 3'd4,
        RS_CMP_LO    = 3'd5,
        RS_CMP_HI    = 3'd6,
        RS_INC       = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/ctmr_prescale.sv
// Prescaler: emits a one-cycle tick every (div+1) cycles while run is high.
// Assumes run and div come from registers. The phase restarts whenever run is low.
module ctmr_prescale #(
    parameter int W = ctmr_pkg::PRE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] phase_q;

    assign tick = run && (phase_q == div);

    // Advance the phase counter, wrapping on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/ctmr_counter.sv
// Shared up-counter: increments on tick, and either half is writable.
// Assumes a write has priority over the increment in the same cycle.
module ctmr_counter
    import ctmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt
);
    logic [CNT_W-1:0] cnt_q;

    assign cnt = cnt_q;

    // Load a half on write, otherwise count on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_lo) begin
            cnt_q[HALF_W-1:0] <= wdata;
        end else if (wr_hi) begin
            cnt_q[CNT_W-1:HALF_W] <= wdata;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ctmr_compare.sv
// Per-core comparator bank: compare value, step, control bits and sticky flag.
// Assumes wr_en is already qualified with this bank's core ID.
// One-shot mode disarms on a match; a compare or control write re-arms.
module ctmr_compare
    import ctmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] rdata,
    output logic              flag,
    output logic              irq_en
);
    logic [CNT_W-1:0]  cmp_q, cmp_nxt;
    logic [HALF_W-1:0] step_q;
    logic              cmp_on_q, ien_q, auto_q, armed_q, flag_q;
    logic              hit, clr, rearm;

    assign hit    = cmp_on_q && armed_q && (cnt >= cmp_q);
    assign clr    = wr_en && (addr == RS_STATUS) && wdata[0];
    assign rearm  = wr_en && ((addr == RS_CORE_CTRL) || (addr == RS_CMP_LO) ||
                              (addr == RS_CMP_HI));
    assign flag   = flag_q;
    assign irq_en = ien_q;

    // Next compare value: auto advance, then any software write on top.
    always_comb begin
        cmp_nxt = cmp_q;
        if (hit && auto_q) cmp_nxt = cmp_q + {{HALF_W{1'b0}}, step_q};
        if (wr_en && addr == RS_CMP_LO) cmp_nxt[HALF_W-1:0] = wdata;
        if (wr_en && addr == RS_CMP_HI) cmp_nxt[CNT_W-1:HALF_W] = wdata;
    end

    // Register update for the bank state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q    <= '0;
            step_q   <= '0;
            cmp_on_q <= 1'b0;
            ien_q    <= 1'b0;
            auto_q   <= 1'b0;
            armed_q  <= 1'b1;
            flag_q   <= 1'b0;
        end else begin
            cmp_q <= cmp_nxt;
            if (hit) flag_q <= 1'b1;
            else if (clr) flag_q <= 1'b0;
            if (rearm) armed_q <= 1'b1;
            else if (hit) armed_q <= auto_q;
            if (wr_en && addr == RS_CORE_CTRL) begin
                cmp_on_q <= wdata[0];
                ien_q    <= wdata[1];
                auto_q   <= wdata[2];
            end
            if (wr_en && addr == RS_INC) step_q <= wdata;
        end
    end

    // Read view of this bank.
    always_comb begin
        case (reg_sel_e'(addr))
            RS_CORE_CTRL: rdata = {{(HALF_W-3){1'b0}}, auto_q, ien_q, cmp_on_q};
            RS_STATUS:    rdata = {{(HALF_W-1){1'b0}}, flag_q};
            RS_CMP_LO:    rdata = cmp_q[HALF_W-1:0];
            RS_CMP_HI:    rdata = cmp_q[CNT_W-1:HALF_W];
            RS_INC:       rdata = step_q;
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/cluster_timer.sv
// Top: shared 64-bit counter with prescaler, and one banked comparator per core.
// Assumes a single clock and a synchronous active-low reset. Reads are registered.
module cluster_timer
    import ctmr_pkg::*;
#(
    parameter int NUM_CORES = 2,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CORE_W-1:0] req_core,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [HALF_W-1:0] req_wdata,
    output logic [HALF_W-1:0] rsp_rdata,
    output logic [NUM_CORES-1:0] irq
);
    logic              run_q;
    logic [PRE_W-1:0]  div_q;
    logic              tick, core_ok, wr_any;
    logic [CNT_W-1:0]  cnt_q;
    logic [NUM_CORES-1:0] flag_vec, ien_vec;
    logic [HALF_W-1:0] bank_rd [NUM_CORES];

    assign core_ok = 32'(req_core) < NUM_CORES;
    assign wr_any  = req_valid && req_write;

    // Global control register, shared by all cores.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            div_q <= '0;
        end else if (wr_any && req_addr == RS_GCTRL) begin
            run_q <= req_wdata[0];
            div_q <= req_wdata[8 +: PRE_W];
        end
    end

    ctmr_prescale #(.W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_q), .div(div_q), .tick(tick)
    );

    ctmr_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_lo(wr_any && req_addr == RS_CNT_LO),
        .wr_hi(wr_any && req_addr == RS_CNT_HI),
        .wdata(req_wdata), .cnt(cnt_q)
    );

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_bank
        ctmr_compare u_cmp (
            .clk(clk), .rst_n(rst_n), .cnt(cnt_q),
            .wr_en(wr_any && core_ok && 32'(req_core) == i),
            .addr(req_addr), .wdata(req_wdata), .rdata(bank_rd[i]),
            .flag(flag_vec[i]), .irq_en(ien_vec[i])
        );
    end

    assign irq = flag_vec & ien_vec;

    // Registered read mux: shared registers first, then the requester's bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (req_valid && !req_write) begin
            case (reg_sel_e'(req_addr))
                RS_CNT_LO: rsp_rdata <= cnt_q[HALF_W-1:0];
                RS_CNT_HI: rsp_rdata <= cnt_q[CNT_W-1:HALF_W];
                RS_GCTRL:  rsp_rdata <= {{(HALF_W-8-PRE_W){1'b0}}, div_q, 7'b0, run_q};
                default:   rsp_rdata <= core_ok ? bank_rd[req_core] : '0;
            endcase
        end
    end
endmodule

// File: rtl/cluster_timer_chk.sv
// Checker: temporal properties of the counter, the flags and the interrupts.
// Assumes it is bound into cluster_timer and sees its internal counter and tick.
module cluster_timer_chk
    import ctmr_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int CORE_W    = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [CORE_W-1:0]    req_core,
    input logic [ADDR_W-1:0]    req_addr,
    input logic                 clr_bit,
    input logic [CNT_W-1:0]     cnt,
    input logic                 tick,
    input logic [NUM_CORES-1:0] flag,
    input logic [NUM_CORES-1:0] irq
);
    logic cnt_wr;
    assign cnt_wr = req_valid && req_write &&
                    (req_addr == RS_CNT_LO || req_addr == RS_CNT_HI);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !cnt_wr |=> cnt == $past(cnt) + 1'b1); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !cnt_wr |=> $stable(cnt)); // R2
    AST_CNT_NEVER_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> cnt >= $past(cnt)); // R10
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~flag) == '0); // R9

    for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            flag[i] && !(req_valid && req_write && req_addr == RS_STATUS &&
                         clr_bit && 32'(req_core) == i) |=> flag[i]); // R8
    end
endmodule

bind cluster_timer cluster_timer_chk #(.NUM_CORES(NUM_CORES), .CORE_W(CORE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_core(req_core), .req_addr(req_addr), .clr_bit(req_wdata[0]),
    .cnt(cnt_q), .tick(tick), .flag(flag_vec), .irq(irq)
);

// File: tb/cluster_timer_bench.sv
// Directed bench for cluster_timer: one task per scenario, each checking itself.
module cluster_timer_bench;
    localparam int NC     = 2;
    localparam int CORE_W = 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [CORE_W-1:0] req_core = '0;
    logic [2:0]        req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [31:0]       rsp_rdata;
    logic [NC-1:0]     irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    cluster_timer #(.NUM_CORES(NC)) u_cluster_timer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_core(req_core), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .irq(irq)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; the write is sampled at the next rising edge.
    task automatic bus_wr(input int core, input logic [2:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_core = CORE_W'(core);
        req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input int core, input logic [2:0] a, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_core = CORE_W'(core); req_addr = a;
        @(negedge clk);
        d = rsp_rdata;
        req_valid = 1'b0;
    endtask

    task automatic wait_irq(input int core, output int at);
        at = -1;
        for (int k = 0; k < 200; k++) begin
            if (irq[core]) begin at = cyc; return; end
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 irq", 64'(irq), 0);
        bus_rd(0, 3'd0, d); chk("R1 cnt_lo", 64'(d), 0);
        bus_rd(0, 3'd2, d); chk("R1 gctrl", 64'(d), 0);
        bus_rd(1, 3'd4, d); chk("R1 status", 64'(d), 0);
        bus_rd(1, 3'd3, d); chk("R11 core_ctrl", 64'(d), 0);
    endtask

    task automatic t_prescale;
        logic [31:0] d;
        bus_wr(0, 3'd2, 32'h0000_0201);      // run, prescale 2
        repeat (5) @(negedge clk);
        bus_wr(0, 3'd2, 32'h0000_0200);      // stop: two ticks taken
        bus_rd(0, 3'd0, d); chk("R2 count /3", 64'(d), 2);
        repeat (6) @(negedge clk);
        bus_rd(1, 3'd0, d); chk("R2 hold", 64'(d), 2);
    endtask

    task automatic t_carry;
        logic [31:0] d;
        bus_wr(0, 3'd0, 32'hFFFF_FFFE);
        bus_wr(0, 3'd1, 32'h0);
        bus_wr(0, 3'd2, 32'h1);
        repeat (3) @(negedge clk);
        bus_wr(0, 3'd2, 32'h0);              // four increments in total
        bus_rd(0, 3'd1, d); chk("R3 hi", 64'(d), 1);
        bus_rd(0, 3'd0, d); chk("R3 lo", 64'(d), 2);
    endtask

    task automatic t_banking;
        logic [31:0] d, e;
        bus_wr(0, 3'd5, 32'h1234);
        bus_wr(0, 3'd7, 32'h7);
        bus_rd(1, 3'd5, d); chk("R4 core1 cmp untouched", 64'(d), 0);
        bus_rd(1, 3'd7, d); chk("R4 core1 step untouched", 64'(d), 0);
        bus_rd(0, 3'd5, d); chk("R4 core0 cmp", 64'(d), 64'h1234);
        bus_wr(1, 3'd7, 32'h55);
        bus_rd(0, 3'd7, d); chk("R4 core0 step kept", 64'(d), 7);
        bus_rd(0, 3'd1, d); bus_rd(1, 3'd1, e);
        chk("R4 shared counter", 64'(e), 64'(d));
    endtask

    task automatic t_match;
        logic [31:0] d;
        bus_wr(0, 3'd1, 32'h0);
        bus_wr(0, 3'd0, 32'd100);            // counter held at 100
        bus_wr(0, 3'd6, 32'h0);
        bus_wr(0, 3'd5, 32'd101);
        bus_wr(0, 3'd3, 32'h3);              // compare + interrupt enable
        repeat (3) @(negedge clk);
        chk("R5 below compare no irq", 64'(irq[0]), 0);
        bus_wr(0, 3'd0, 32'd101);
        chk("R5 not before one cycle", 64'(irq[0]), 0);
        @(negedge clk);
        chk("R5 fires on reach", 64'(irq[0]), 1);
        bus_wr(0, 3'd4, 32'h0);
        chk("R8 write 0 keeps flag", 64'(irq[0]), 1);
        bus_wr(0, 3'd4, 32'h1);
        repeat (4) @(negedge clk);
        bus_rd(0, 3'd4, d); chk("R6 one-shot stays clear", 64'(d), 0);
        bus_wr(0, 3'd5, 32'd90);             // compare in the past, re-arms
        @(negedge clk);
        chk("R5 past compare fires", 64'(irq[0]), 1);
        bus_wr(0, 3'd4, 32'h1);
        chk("R8 cleared", 64'(irq[0]), 0);
    endtask

    task automatic t_irq_gate;
        logic [31:0] d;
        bus_wr(1, 3'd6, 32'h0);
        bus_wr(1, 3'd5, 32'd50);
        bus_wr(1, 3'd3, 32'h1);              // compare only, no interrupt
        repeat (2) @(negedge clk);
        bus_rd(1, 3'd4, d); chk("R9 flag set", 64'(d), 1);
        chk("R9 masked irq", 64'(irq[1]), 0);
        chk("R4 core0 irq unaffected", 64'(irq[0]), 0);
        bus_wr(1, 3'd3, 32'h3);
        chk("R9 enabled irq", 64'(irq[1]), 1);
        bus_wr(1, 3'd3, 32'h0);
        bus_wr(1, 3'd4, 32'h1);
    endtask

    task automatic t_auto;
        logic [31:0] v1, v2;
        int c1, c2, c3, c4;
        bus_wr(0, 3'd3, 32'h0);
        bus_wr(0, 3'd0, 32'h0);
        bus_wr(0, 3'd1, 32'h0);
        bus_wr(1, 3'd6, 32'h0);
        bus_wr(1, 3'd5, 32'd10);
        bus_wr(1, 3'd7, 32'd10);
        bus_wr(1, 3'd3, 32'h7);              // compare, interrupt, auto
        bus_wr(1, 3'd4, 32'h1);
        bus_wr(0, 3'd2, 32'h1);              // run, prescale 0
        wait_irq(1, c1);
        bus_wr(1, 3'd4, 32'h1);
        wait_irq(1, c2);
        chk("R7 period step 10", 64'(c2 - c1), 10);
        bus_rd(0, 3'd0, v1);
        repeat (20) @(negedge clk);
        bus_rd(0, 3'd0, v2);
        chk("R10 counter runs across match", 64'(v2 - v1), 21);
        bus_wr(0, 3'd2, 32'h101);            // prescale 1
        bus_wr(1, 3'd4, 32'h1);
        wait_irq(1, c3);
        bus_wr(1, 3'd4, 32'h1);
        wait_irq(1, c3);
        bus_wr(1, 3'd4, 32'h1);
        wait_irq(1, c4);
        chk("R7 period with prescale", 64'(c4 - c3), 20);
        bus_wr(0, 3'd2, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prescale();
        t_carry();
        t_banking();
        t_match();
        t_irq_gate();
        t_auto();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule